// File: doc/BRIEF.md
# NAND Flash Host Command Sequencer

This block sits on the host side of an 8-bit multiplexed NAND flash bus. It takes one request at a time on a valid/ready interface and expands it into the exact series of command, address and data bus cycles the flash expects. The supported operations are page read, page program, block erase, status read, ID read and device reset. It drives chip enable, the write and read strobes, and the command and address latch enables. The data bus is presented as a separate output value, an output-enable and an input value, so the pad ring can build the tristate. A ready/busy input gates every step that has to wait for the flash.

Bus timing is set by parameters. These give the number of clock cycles for strobe setup, strobe low time and strobe hold. Every write-type byte is captured by the flash on the rising edge of the write strobe. Read bytes are sampled in the last cycle that the read strobe is low. After a program or an erase, the sequencer reads the flash status byte by itself. It returns that byte to the user with bit 0 as the pass/fail flag.

Top module: `nand_cmd_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle (req_ready high), chip enable is high and both strobes are high. Both latch enables and the data output-enable are low.
- R2: Every bus byte is transferred with chip enable low. The strobe stays low for exactly PULSE_CYC cycles, and the byte on nf_dq_out is held stable while the write strobe is low.
- R3: nf_cle is high only for command bytes and nf_ale only for address bytes. The two are never high together, and neither changes while the write strobe is low.
- R4: A page read sends command 00h when req_region is 0 (first half), 01h when it is 1 (second half) and 50h when it is 2 or 3 (spare area). Three address bytes follow: req_col, row[7:0], then row[12:8] zero-extended.
- R5: After the read address, the block waits for nf_rb high and then performs req_len read strobes. Each sampled byte appears once on rd_data with rd_valid, in bus order.
- R6: A program (req_op 1) sends 80h and the three address bytes of R4. It then sends req_len bytes taken from the wd_valid/wd_ready stream in order, then 10h.
- R7: A block erase (req_op 2) sends 60h, row[7:0], row[12:8] and D0h, with no column byte.
- R8: After a program or erase, the block waits for nf_rb high, sends 70h and reads one byte. It returns that byte on rsp_status, with rsp_fail equal to its bit 0.
- R9: A status read (req_op 3) sends 70h, reads one byte and returns it as in R8.
- R10: An ID read (req_op 4) sends 90h and one address byte 00h, then reads req_len bytes as in R5 without waiting on nf_rb.
- R11: A reset (req_op 5) sends FFh and completes only after nf_rb is high again, with rsp_fail low. A page read (req_op 0) also reports rsp_fail low.
- R12: No strobe is driven while nf_rb is low. req_ready is high only when no operation is in progress. rsp_valid is a single-cycle pulse per accepted request.
- R13: req_op values 6 and 7 produce no bus cycle and are answered with rsp_fail high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 3 | 0 read, 1 program, 2 erase, 3 status, 4 ID, 5 reset |
| req_region | input | 2 | Read start area: 0 first half, 1 second half, 2/3 spare |
| req_col | input | 8 | Column byte |
| req_row | input | ROW_W | Page row address |
| req_len | input | LEN_W | Data bytes to read or program |
| wd_valid | input | 1 | Program data byte offered |
| wd_ready | output | 1 | Program data byte taken |
| wd_data | input | 8 | Program data byte |
| rd_valid | output | 1 | Read byte valid (one cycle) |
| rd_data | output | 8 | Read byte |
| rsp_valid | output | 1 | Operation finished (one cycle) |
| rsp_fail | output | 1 | Failure flag |
| rsp_status | output | 8 | Status byte read from the flash |
| nf_ce_n | output | 1 | Chip enable, low active |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_we_n | output | 1 | Write strobe, low active |
| nf_re_n | output | 1 | Read strobe, low active |
| nf_dq_out | output | 8 | Bus value driven |
| nf_dq_oe | output | 1 | Bus drive enable |
| nf_dq_in | input | 8 | Bus value received |
| nf_rb | input | 1 | Flash ready (high) / busy (low) |

## Verification
A written byte is due at the rising edge of the write strobe. That edge comes SETUP_CYC + PULSE_CYC cycles after the byte's cycle begins. The bench's flash model therefore captures bytes at that edge and measures the low time there. It does not use a fixed cycle offset from the request. A read byte reaches rd_valid one cycle after its strobe-hold phase ends. The wait on the ready/busy line adds WB_CYC cycles plus the synchronizer depth, so the bench collects read bytes and responses whenever rd_valid and rsp_valid pulse, and compares them in order. Protocol rules (latch-enable exclusivity, chip enable during strobes, silence while busy) are checked on every clock at the falling edge.

// File: rtl/nand_seq_pkg.sv
// Shared types and command codes for the NAND host sequencer.
// Assumes an 8-bit multiplexed flash bus with one command per bus cycle.
package nand_seq_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_STATUS = 3'd3,
        OP_ID     = 3'd4,
        OP_RESET  = 3'd5
    } nf_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_CMD, S_ADDR, S_WDATA, S_CMD2,
        S_WAIT, S_RDATA, S_ST_CMD, S_ST_RD, S_RSP
    } seq_state_e;

    typedef enum logic [1:0] {P_IDLE, P_SETUP, P_LOW, P_HOLD} phy_state_e;

    localparam logic [7:0] C_RD_LO   = 8'h00;
    localparam logic [7:0] C_RD_HI   = 8'h01;
    localparam logic [7:0] C_RD_SP   = 8'h50;
    localparam logic [7:0] C_PROG_LD = 8'h80;
    localparam logic [7:0] C_PROG_GO = 8'h10;
    localparam logic [7:0] C_ERS_LD  = 8'h60;
    localparam logic [7:0] C_ERS_GO  = 8'hD0;
    localparam logic [7:0] C_STAT    = 8'h70;
    localparam logic [7:0] C_ID      = 8'h90;
    localparam logic [7:0] C_RST     = 8'hFF;

    // One bus transfer as handed from the sequencer to the bus engine.
    typedef struct packed {
        logic       cle;
        logic       ale;
        logic       rd;
        logic [7:0] data;
    } bus_req_t;

endpackage

// File: rtl/nand_rb_sync.sv
// Synchronizes the asynchronous ready/busy line into the clock domain.
// Assumes STAGES >= 1; resets to "busy" so nothing proceeds before a sample.
module nand_rb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= async_in;
            end
        end else begin : g_many
            // Shift chain of capture flops.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/nand_bus_phy.sv
// Executes one flash bus transfer (write-type or read) with parameterised
// setup, strobe-low and hold cycle counts. Latch enables and the driven byte
// are set while both strobes are high and cleared only after the hold phase.
// Assumes every cycle count is at least 1.
module nand_bus_phy
    import nand_seq_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 2,
    parameter int HOLD_CYC  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  bus_req_t   req,
    output logic       ready,
    output logic       done,
    output logic [7:0] rbyte,
    output logic       we_n,
    output logic       re_n,
    output logic       cle,
    output logic       ale,
    output logic [7:0] dq_out,
    output logic       dq_oe,
    input  logic [7:0] dq_in
);
    localparam int MAXC = (SETUP_CYC > PULSE_CYC)
                        ? ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC)
                        : ((PULSE_CYC > HOLD_CYC) ? PULSE_CYC : HOLD_CYC);
    localparam int CW = $clog2(MAXC + 1);

    phy_state_e    st;
    logic [CW-1:0] cnt;
    logic          rd_q;

    // Phase sequencer: setup -> strobe low -> hold, one transfer per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= P_IDLE;
            cnt    <= '0;
            rd_q   <= 1'b0;
            we_n   <= 1'b1;
            re_n   <= 1'b1;
            cle    <= 1'b0;
            ale    <= 1'b0;
            dq_out <= '0;
            dq_oe  <= 1'b0;
            rbyte  <= '0;
        end else begin
            unique case (st)
                P_IDLE: if (start) begin
                    st     <= P_SETUP;
                    cnt    <= CW'(SETUP_CYC - 1);
                    cle    <= req.cle;
                    ale    <= req.ale;
                    dq_out <= req.data;
                    dq_oe  <= !req.rd;
                    rd_q   <= req.rd;
                end
                P_SETUP: if (cnt == '0) begin
                    st  <= P_LOW;
                    cnt <= CW'(PULSE_CYC - 1);
                    if (rd_q) re_n <= 1'b0;
                    else      we_n <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                P_LOW: if (cnt == '0) begin
                    st   <= P_HOLD;
                    cnt  <= CW'(HOLD_CYC - 1);
                    we_n <= 1'b1;
                    re_n <= 1'b1;
                    if (rd_q) rbyte <= dq_in;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                P_HOLD: if (cnt == '0) begin
                    st    <= P_IDLE;
                    cle   <= 1'b0;
                    ale   <= 1'b0;
                    dq_oe <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= P_IDLE;
            endcase
        end
    end

    assign ready = (st == P_IDLE);
    assign done  = (st == P_HOLD) && (cnt == '0);
endmodule

// File: rtl/nand_seq_ctrl.sv
// Operation sequencer: turns one accepted request into its ordered list of
// command, address, data and status transfers, waiting on ready/busy where
// the flash is working. Assumes the bus engine accepts a start only when idle.
module nand_seq_ctrl
    import nand_seq_pkg::*;
#(
    parameter int ROW_W  = 13,
    parameter int LEN_W  = 10,
    parameter int WB_CYC = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_region,
    input  logic [7:0]       req_col,
    input  logic [ROW_W-1:0] req_row,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wd_valid,
    output logic             wd_ready,
    input  logic [7:0]       wd_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rsp_valid,
    output logic             rsp_fail,
    output logic [7:0]       rsp_status,
    output logic             ce_n,
    input  logic             rb_ok,
    output logic             phy_start,
    output bus_req_t         phy_req,
    input  logic             phy_ready,
    input  logic             phy_done,
    input  logic [7:0]       phy_rbyte
);
    localparam int WW = $clog2(WB_CYC + 1);

    seq_state_e       state, state_d;
    logic [2:0]       op_q;
    logic [1:0]       region_q;
    logic [7:0]       col_q;
    logic [ROW_W-1:0] row_q;
    logic [LEN_W-1:0] len_q, cnt;
    logic [1:0]       addr_idx;
    logic [7:0]       status_q;
    logic [WW-1:0]    wait_cnt;
    logic             inflight;
    logic             bad_op, len_zero, cnt_last, addr_last, is_bus, stat_op;
    logic [7:0]       first_cmd, abyte;

    assign bad_op    = (req_op > OP_RESET);
    assign len_zero  = (len_q == '0);
    assign cnt_last  = (cnt == len_q - 1'b1);
    assign addr_last = (addr_idx == 2'd2) || (addr_idx == 2'd3);
    assign stat_op   = (op_q == OP_PROG) || (op_q == OP_ERASE) || (op_q == OP_STATUS);

    // First command byte for the latched operation and read region.
    always_comb begin
        unique case (op_q)
            OP_READ:   first_cmd = (region_q == 2'd0) ? C_RD_LO
                                 : (region_q == 2'd1) ? C_RD_HI : C_RD_SP;
            OP_PROG:   first_cmd = C_PROG_LD;
            OP_ERASE:  first_cmd = C_ERS_LD;
            OP_STATUS: first_cmd = C_STAT;
            OP_ID:     first_cmd = C_ID;
            default:   first_cmd = C_RST;
        endcase
    end

    // Address byte for the current address slot (3 = ID dummy byte).
    always_comb begin
        unique case (addr_idx)
            2'd0:    abyte = col_q;
            2'd1:    abyte = row_q[7:0];
            2'd2:    abyte = 8'(row_q >> 8);
            default: abyte = 8'h00;
        endcase
    end

    // Transfer request presented to the bus engine in each state.
    always_comb begin
        phy_req = '0;
        is_bus  = 1'b1;
        unique case (state)
            S_CMD:    begin phy_req.cle = 1'b1; phy_req.data = first_cmd; end
            S_ADDR:   begin phy_req.ale = 1'b1; phy_req.data = abyte; end
            S_WDATA:  phy_req.data = wd_data;
            S_CMD2:   begin
                phy_req.cle  = 1'b1;
                phy_req.data = (op_q == OP_PROG) ? C_PROG_GO : C_ERS_GO;
            end
            S_ST_CMD: begin phy_req.cle = 1'b1; phy_req.data = C_STAT; end
            S_RDATA, S_ST_RD: phy_req.rd = 1'b1;
            default:  is_bus = 1'b0;
        endcase
    end

    assign phy_start = is_bus && phy_ready && !inflight && ((state != S_WDATA) || wd_valid);
    assign wd_ready  = phy_start && (state == S_WDATA);

    // Next-state selection for the operation sequence.
    always_comb begin
        state_d = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_d = bad_op ? S_RSP : S_CMD;
            S_CMD:   if (phy_done) begin
                if (op_q == OP_RESET)       state_d = S_WAIT;
                else if (op_q == OP_STATUS) state_d = S_ST_RD;
                else                        state_d = S_ADDR;
            end
            S_ADDR:  if (phy_done && addr_last) begin
                unique case (op_q)
                    OP_READ:  state_d = S_WAIT;
                    OP_PROG:  state_d = len_zero ? S_CMD2 : S_WDATA;
                    OP_ERASE: state_d = S_CMD2;
                    default:  state_d = len_zero ? S_RSP : S_RDATA;
                endcase
            end
            S_WDATA: if (phy_done && cnt_last) state_d = S_CMD2;
            S_CMD2:  if (phy_done) state_d = S_WAIT;
            S_WAIT:  if (wait_cnt == '0 && rb_ok) begin
                if (op_q == OP_READ)       state_d = len_zero ? S_RSP : S_RDATA;
                else if (op_q == OP_RESET) state_d = S_RSP;
                else                       state_d = S_ST_CMD;
            end
            S_RDATA:  if (phy_done && cnt_last) state_d = S_RSP;
            S_ST_CMD: if (phy_done) state_d = S_ST_RD;
            S_ST_RD:  if (phy_done) state_d = S_RSP;
            S_RSP:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State, request latch, counters and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ce_n     <= 1'b1;
            op_q     <= '0;
            region_q <= '0;
            col_q    <= '0;
            row_q    <= '0;
            len_q    <= '0;
            cnt      <= '0;
            addr_idx <= '0;
            status_q <= '0;
            wait_cnt <= '0;
            inflight <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            state    <= state_d;
            ce_n     <= (state_d == S_IDLE) || (state_d == S_RSP);
            rd_valid <= phy_done && (state == S_RDATA);
            if (phy_done && state == S_RDATA) rd_data <= phy_rbyte;

            if (phy_done)       inflight <= 1'b0;
            else if (phy_start) inflight <= 1'b1;

            if (state == S_IDLE && req_valid) begin
                op_q     <= req_op;
                region_q <= req_region;
                col_q    <= req_col;
                row_q    <= req_row;
                len_q    <= req_len;
                status_q <= '0;
                addr_idx <= (req_op == OP_ERASE) ? 2'd1 : (req_op == OP_ID) ? 2'd3 : 2'd0;
            end else if (state == S_ADDR && phy_done && !addr_last) begin
                addr_idx <= addr_idx + 2'd1;
            end

            if (state_d != state)
                cnt <= '0;
            else if (phy_done && (state == S_WDATA || state == S_RDATA))
                cnt <= cnt + 1'b1;

            if (state_d == S_WAIT && state != S_WAIT)
                wait_cnt <= WW'(WB_CYC);
            else if (state == S_WAIT && wait_cnt != '0)
                wait_cnt <= wait_cnt - 1'b1;

            if (state == S_ST_RD && phy_done) status_q <= phy_rbyte;
        end
    end

    assign req_ready  = (state == S_IDLE);
    assign rsp_valid  = (state == S_RSP);
    assign rsp_status = status_q;
    assign rsp_fail   = (op_q > OP_RESET) ? 1'b1 : (stat_op ? status_q[0] : 1'b0);
endmodule

// File: rtl/nand_cmd_seq.sv
// Top of the NAND host command sequencer: request sequencer, bus transfer
// engine and ready/busy synchronizer. The data bus is split into out/oe/in
// for the pad ring. Assumes a single flash die on the bus.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int SETUP_CYC   = 1,
    parameter int PULSE_CYC   = 2,
    parameter int HOLD_CYC    = 1,
    parameter int WB_CYC      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int ROW_W       = 13,
    parameter int LEN_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_region,
    input  logic [7:0]       req_col,
    input  logic [ROW_W-1:0] req_row,
    input  logic [LEN_W-1:0] req_len,
    input  logic             wd_valid,
    output logic             wd_ready,
    input  logic [7:0]       wd_data,
    output logic             rd_valid,
    output logic [7:0]       rd_data,
    output logic             rsp_valid,
    output logic             rsp_fail,
    output logic [7:0]       rsp_status,
    output logic             nf_ce_n,
    output logic             nf_cle,
    output logic             nf_ale,
    output logic             nf_we_n,
    output logic             nf_re_n,
    output logic [7:0]       nf_dq_out,
    output logic             nf_dq_oe,
    input  logic [7:0]       nf_dq_in,
    input  logic             nf_rb
);
    logic       rb_ok, phy_start, phy_ready, phy_done;
    logic [7:0] phy_rbyte;
    bus_req_t   phy_req;

    nand_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(nf_rb), .sync_out(rb_ok)
    );

    nand_seq_ctrl #(.ROW_W(ROW_W), .LEN_W(LEN_W), .WB_CYC(WB_CYC)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_region(req_region), .req_col(req_col), .req_row(req_row),
        .req_len(req_len), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_data(wd_data), .rd_valid(rd_valid), .rd_data(rd_data),
        .rsp_valid(rsp_valid), .rsp_fail(rsp_fail), .rsp_status(rsp_status),
        .ce_n(nf_ce_n), .rb_ok(rb_ok), .phy_start(phy_start),
        .phy_req(phy_req), .phy_ready(phy_ready), .phy_done(phy_done),
        .phy_rbyte(phy_rbyte)
    );

    nand_bus_phy #(.SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)) u_phy (
        .clk(clk), .rst_n(rst_n), .start(phy_start), .req(phy_req),
        .ready(phy_ready), .done(phy_done), .rbyte(phy_rbyte),
        .we_n(nf_we_n), .re_n(nf_re_n), .cle(nf_cle), .ale(nf_ale),
        .dq_out(nf_dq_out), .dq_oe(nf_dq_oe), .dq_in(nf_dq_in)
    );
endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Protocol checker for the NAND host sequencer, bound to every instance.
// Observes only top-level ports.
module nand_cmd_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_ready,
    input logic       rsp_valid,
    input logic       nf_ce_n,
    input logic       nf_cle,
    input logic       nf_ale,
    input logic       nf_we_n,
    input logic       nf_re_n,
    input logic [7:0] nf_dq_out,
    input logic       nf_dq_oe,
    input logic       nf_rb
);
    // R1: idle bus is quiet.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe));
    // R2: chip enable low during any strobe.
    a_r2_ce_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n || !nf_re_n) |-> !nf_ce_n);
    // R2: driven byte stable and enabled while write strobe low.
    a_r2_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!nf_we_n && !$past(nf_we_n)) |-> ($stable(nf_dq_out) && nf_dq_oe));
    // R3: latch enables exclusive.
    a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));
    // R3: latch enables frozen while write strobe low.
    a_r3_latch_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_we_n |-> ($stable(nf_cle) && $stable(nf_ale)));
    // R5: bus not driven during a read strobe.
    a_r5_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_re_n |-> !nf_dq_oe);
    // R12: no strobe while flash busy.
    a_r12_quiet_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !nf_rb |-> (nf_we_n && nf_re_n));
    // R12: ready only while chip deselected.
    a_r12_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> nf_ce_n);
    // R12: response is a single-cycle pulse.
    a_r12_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .nf_ce_n(nf_ce_n), .nf_cle(nf_cle), .nf_ale(nf_ale), .nf_we_n(nf_we_n),
    .nf_re_n(nf_re_n), .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_rb(nf_rb)
);

// File: tb/tb_nand_cmd_seq.sv
// Bench: behavioural flash model that logs every latched byte, supplies read
// bytes and busy periods, plus per-clock protocol checks and per-op compares.
module tb_nand_cmd_seq;
    localparam int TS = 2, TP = 3, TH = 1, WB = 4, BUSY_T = 20;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [2:0] req_op = '0;
    logic [1:0] req_region = '0;
    logic [7:0] req_col = '0;
    logic [12:0] req_row = '0;
    logic [9:0] req_len = '0;
    logic wd_valid = 1'b0, wd_ready;
    logic [7:0] wd_data;
    logic rd_valid, rsp_valid, rsp_fail;
    logic [7:0] rd_data, rsp_status;
    logic nf_ce_n, nf_cle, nf_ale, nf_we_n, nf_re_n, nf_dq_oe;
    logic [7:0] nf_dq_out;
    logic [7:0] nf_dq_in = '0;
    logic nf_rb = 1'b1;

    int checks = 0, fails = 0;
    int log_q[$], exp_log[$];
    int rd_q[$], exp_rd[$];
    int wd_idx = 0;
    logic [7:0] st_value = '0;

    always #2.5 clk = ~clk;

    nand_cmd_seq #(.SETUP_CYC(TS), .PULSE_CYC(TP), .HOLD_CYC(TH), .WB_CYC(WB)) dut (.*);

    function automatic logic [7:0] prog_byte(int i); return 8'(i * 29 + 7); endfunction
    function automatic logic [7:0] id_byte(int i);   return 8'(8'h3C + i * 17); endfunction
    function automatic logic [7:0] page_byte(logic [7:0] c, logic [7:0] col, logic [7:0] rl, int i);
        return c ^ col ^ rl ^ 8'(i * 5);
    endfunction

    assign wd_data = prog_byte(wd_idx);
    always @(posedge clk) if (wd_valid && wd_ready) wd_idx <= wd_idx + 1;

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Flash model and per-clock protocol checks, all at the falling edge.
    logic we_prev = 1'b1, re_prev = 1'b1;
    int we_low = 0, busy_cnt = 0, addr_n = 0, rd_idx = 0;
    logic [7:0] last_cmd = 8'hFF;
    logic [7:0] addr_b [3];
    always @(negedge clk) begin
        if (rst_n) begin
            check(!(nf_cle && nf_ale), "R3 cle/ale together", {nf_cle, nf_ale}, 0);
            check(!((!nf_we_n || !nf_re_n) && nf_ce_n), "R2 strobe with ce high", nf_ce_n, 0);
            check(nf_rb || (nf_we_n && nf_re_n), "R12 strobe while busy", {nf_we_n, nf_re_n}, 3);
            check(!req_ready || nf_ce_n, "R12 ready with ce low", nf_ce_n, 1);
            if (rd_valid) rd_q.push_back(int'(rd_data));
            if (!we_prev && nf_we_n) begin
                check(we_low == TP, "R2 write strobe width", we_low, TP);
                we_low = 0;
                if (nf_cle) begin
                    log_q.push_back('h200 | int'(nf_dq_out));
                    last_cmd = nf_dq_out; addr_n = 0; rd_idx = 0;
                    if (nf_dq_out == 8'h10 || nf_dq_out == 8'hD0 || nf_dq_out == 8'hFF)
                        busy_cnt = BUSY_T;
                end else if (nf_ale) begin
                    log_q.push_back('h100 | int'(nf_dq_out));
                    if (addr_n < 3) addr_b[addr_n] = nf_dq_out;
                    addr_n++;
                    if (addr_n == 3 && (last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50))
                        busy_cnt = BUSY_T;
                end else begin
                    log_q.push_back(int'(nf_dq_out));
                end
            end
            if (!nf_we_n) we_low++;
            if (re_prev && !nf_re_n) begin
                if (last_cmd == 8'h70)      nf_dq_in = st_value;
                else if (last_cmd == 8'h90) nf_dq_in = id_byte(rd_idx);
                else nf_dq_in = page_byte(last_cmd, addr_b[0], addr_b[1], rd_idx);
                rd_idx++;
            end
            if (busy_cnt > 0) busy_cnt--;
            nf_rb = (busy_cnt == 0);
        end
        we_prev = nf_we_n;
        re_prev = nf_re_n;
    end

    task automatic run_op(int op, int region, int col, int row, int len, logic [7:0] st, string tag);
        int  rlo = row & 'hFF, rhi = row >> 8, guard = 0;
        logic [7:0] c;
        bit got_fail;
        logic [7:0] got_st;
        log_q.delete(); rd_q.delete(); exp_log.delete(); exp_rd.delete();
        st_value = st;
        case (op)
            0: begin
                c = (region == 0) ? 8'h00 : (region == 1) ? 8'h01 : 8'h50;
                exp_log = '{'h200 | int'(c), 'h100 | col, 'h100 | rlo, 'h100 | rhi};
                for (int i = 0; i < len; i++) exp_rd.push_back(int'(page_byte(c, 8'(col), 8'(rlo), i)));
            end
            1: begin
                exp_log = '{'h280, 'h100 | col, 'h100 | rlo, 'h100 | rhi};
                for (int i = 0; i < len; i++) exp_log.push_back(int'(prog_byte(i)));
                exp_log.push_back('h210); exp_log.push_back('h270);
            end
            2: exp_log = '{'h260, 'h100 | rlo, 'h100 | rhi, 'h2D0, 'h270};
            3: exp_log = '{'h270};
            4: begin
                exp_log = '{'h290, 'h100};
                for (int i = 0; i < len; i++) exp_rd.push_back(int'(id_byte(i)));
            end
            5: exp_log = '{'h2FF};
            default: ;
        endcase
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_op = 3'(op); req_region = 2'(region); req_col = 8'(col);
        req_row = 13'(row); req_len = 10'(len); req_valid = 1'b1;
        wd_idx = 0; wd_valid = (op == 1);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, {tag, " R12 busy after accept"}, req_ready, 0);
        while (!rsp_valid && guard < 20000) begin @(negedge clk); guard++; end
        got_fail = rsp_fail; got_st = rsp_status;
        @(negedge clk);
        check(!rsp_valid, {tag, " R12 single response"}, rsp_valid, 0);
        wd_valid = 1'b0;
        check(log_q.size() == exp_log.size(), {tag, " bus byte count"}, log_q.size(), exp_log.size());
        for (int i = 0; i < exp_log.size() && i < log_q.size(); i++)
            check(log_q[i] == exp_log[i], {tag, " bus byte"}, log_q[i], exp_log[i]);
        check(rd_q.size() == exp_rd.size(), {tag, " read count"}, rd_q.size(), exp_rd.size());
        for (int i = 0; i < exp_rd.size() && i < rd_q.size(); i++)
            check(rd_q[i] == exp_rd[i], {tag, " read byte"}, rd_q[i], exp_rd[i]);
        if (op == 1 || op == 2 || op == 3) begin
            check(got_st == st, {tag, " R8 status byte"}, got_st, st);
            check(got_fail == st[0], {tag, " R8 fail flag"}, got_fail, st[0]);
        end else begin
            check(got_fail == (op > 5), {tag, " fail flag"}, got_fail, op > 5);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(nf_ce_n && nf_we_n && nf_re_n && !nf_cle && !nf_ale && !nf_dq_oe && req_ready,
              "R1 reset state", {nf_ce_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe, req_ready}, 'b1110001);
        run_op(0, 0, 'h12, 'h1ABC, 4, 8'h00, "R4 R5 read first half");
        run_op(0, 1, 'h80, 'h0003, 2, 8'h00, "R4 R5 read second half");
        run_op(0, 2, 'h05, 'h1234, 3, 8'h00, "R4 read spare");
        run_op(0, 3, 'h0F, 'h0100, 1, 8'h00, "R4 read spare code 3");
        run_op(1, 0, 'h00, 'h1FFF, 5, 8'hC0, "R6 R8 program pass");
        run_op(1, 0, 'hFE, 'h0001, 1, 8'hC1, "R6 R8 program fail");
        run_op(2, 0, 'h33, 'h0800, 0, 8'hC1, "R7 R8 erase fail");
        run_op(2, 0, 'h00, 'h1F01, 0, 8'hE0, "R7 R8 erase pass");
        run_op(3, 0, 0, 0, 0, 8'hE1, "R9 status");
        run_op(4, 0, 0, 0, 2, 8'h00, "R10 id");
        run_op(5, 0, 0, 0, 0, 8'h00, "R11 reset");
        run_op(6, 0, 1, 2, 3, 8'h00, "R13 unsupported 6");
        run_op(7, 1, 1, 2, 3, 8'h00, "R13 unsupported 7");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule